// File: doc/BRIEF.md
# Registered Eight-Operation ALU

This block is a synchronous arithmetic and logic unit whose operand width is a parameter. Each rising clock edge it takes two operands and a three-bit operation code and stores four values: an N-bit result, a carry flag, an overflow flag and a zero flag. Add and subtract come in separate signed and unsigned forms, so the caller picks which flag applies by choosing the opcode. The other operations are bitwise AND, OR and XOR, and halving of the first operand.

The block has one register stage, so results appear one cycle after the operands. A synchronous, active-high reset clears all four outputs. The adder is built in one of two ways, chosen by a parameter: a behavioural sum or an explicit ripple chain. Both give identical results.

Top module: `reg_alu`

## Requirements
- R1: Opcode 3'b000 gives opa+opb and 3'b001 gives opa+opb. Opcode 3'b010 gives opa-opb and 3'b011 gives opa-opb. All four results wrap modulo 2^WIDTH.
- R2: Opcode 3'b100 gives opa AND opb, 3'b101 gives opa OR opb, and 3'b110 gives opa XOR opb.
- R3: Opcode 3'b111 shifts opa right by one bit and fills the top bit with 0. The value of opb has no effect on the result.
- R4: For opcode 3'b000, carry equals the carry out of the top bit of the unsigned sum.
- R5: For opcode 3'b010, carry is 1 exactly when opa < opb as unsigned numbers. This is the borrow, which is the case where the top-bit carry of opa + ~opb + 1 is 0.
- R6: For opcode 3'b001, ovf is 1 when both operands have the same sign bit and the result's sign bit differs from it.
- R7: For opcode 3'b011, ovf is 1 when the operands' sign bits differ and the result's sign bit differs from opa's sign bit.
- R8: carry is 0 for opcodes 3'b001, 3'b011 and 3'b100 through 3'b111. ovf is 0 for opcodes 3'b000, 3'b010 and 3'b100 through 3'b111.
- R9: Outside reset, zero is 1 exactly when the registered result is all zeros.
- R10: Outputs change only at a rising clock edge. They reflect the inputs sampled at that edge, so the latency is one cycle.
- R11: While rst is high at a rising edge, result, carry, ovf and zero are all cleared to 0.
- R12: WIDTH sets the operand and result width without editing the body. Widths below 2 are rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| opcode | input | 3 | Operation select |
| result | output | WIDTH | Registered result |
| carry | output | 1 | Registered carry/borrow flag |
| ovf | output | 1 | Registered signed overflow flag |
| zero | output | 1 | Registered all-zero flag |

## Verification
The checker assumes opa, opb and opcode are stable and known at every rising edge. Its properties compare each output with the inputs of the edge before, so the checker also assumes rst is high from time zero. The bench drives inputs only at falling edges and raises reset before the first edge. It also drives known values throughout, including the don't-care opb of the halving operation, which it varies on purpose.

// File: rtl/reg_alu_pkg.sv
package reg_alu_pkg;

   typedef enum logic [2:0] {
      OP_ADD_U = 3'b000,
      OP_ADD_S = 3'b001,
      OP_SUB_U = 3'b010,
      OP_SUB_S = 3'b011,
      OP_AND   = 3'b100,
      OP_OR    = 3'b101,
      OP_XOR   = 3'b110,
      OP_HALF  = 3'b111
   } alu_op_e;

   localparam int ADDER_BEHAVIOURAL = 0;
   localparam int ADDER_RIPPLE      = 1;

   function automatic logic op_is_arith(input alu_op_e op);
      return (op == OP_ADD_U) || (op == OP_ADD_S) ||
             (op == OP_SUB_U) || (op == OP_SUB_S);
   endfunction

   function automatic logic op_is_sub(input alu_op_e op);
      return (op == OP_SUB_U) || (op == OP_SUB_S);
   endfunction

endpackage

// File: rtl/reg_alu_addsub.sv
module reg_alu_addsub #(
   parameter int WIDTH = 8,
   parameter int STYLE = 0
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             sub,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   localparam int EXT = WIDTH + 1;

   logic [WIDTH-1:0] b_eff;
   assign b_eff = b ^ {WIDTH{sub}};

   generate
      if (STYLE == reg_alu_pkg::ADDER_RIPPLE) begin : g_ripple
         logic [WIDTH:0] chain;
         assign chain[0] = sub;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]     = a[i] ^ b_eff[i] ^ chain[i];
            assign chain[i+1] = (a[i] & b_eff[i]) | (chain[i] & (a[i] ^ b_eff[i]));
         end
         assign cout = chain[WIDTH];
      end else begin : g_behav
         logic [EXT-1:0] wide;
         assign wide = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
         assign sum  = wide[WIDTH-1:0];
         assign cout = wide[WIDTH];
      end
   endgenerate
endmodule

// File: rtl/reg_alu_logic.sv
module reg_alu_logic #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0]     a,
   input  logic [WIDTH-1:0]     b,
   input  reg_alu_pkg::alu_op_e op,
   output logic [WIDTH-1:0]     res
);
   import reg_alu_pkg::*;

   always_comb begin
      unique case (op)
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         OP_HALF: res = {1'b0, a[WIDTH-1:1]};
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/reg_alu_flags.sv
module reg_alu_flags (
   input  reg_alu_pkg::alu_op_e op,
   input  logic                 a_msb,
   input  logic                 b_msb,
   input  logic                 s_msb,
   input  logic                 cout,
   output logic                 carry_n,
   output logic                 ovf_n
);
   import reg_alu_pkg::*;

   logic add_wrap;
   logic sub_wrap;

   assign add_wrap = (a_msb == b_msb) && (s_msb != a_msb);
   assign sub_wrap = (a_msb != b_msb) && (s_msb != a_msb);

   always_comb begin
      carry_n = 1'b0;
      ovf_n   = 1'b0;
      unique case (op)
         OP_ADD_U: carry_n = cout;
         OP_SUB_U: carry_n = ~cout;
         OP_ADD_S: ovf_n   = add_wrap;
         OP_SUB_S: ovf_n   = sub_wrap;
         default: begin
            carry_n = 1'b0;
            ovf_n   = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/reg_alu.sv
module reg_alu #(
   parameter int WIDTH       = 8,
   parameter int ADDER_STYLE = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic [2:0]       opcode,
   output logic [WIDTH-1:0] result,
   output logic             carry,
   output logic             ovf,
   output logic             zero
);
   import reg_alu_pkg::*;

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("reg_alu: WIDTH must be at least 2");
      end
      if (ADDER_STYLE != ADDER_BEHAVIOURAL && ADDER_STYLE != ADDER_RIPPLE) begin : g_bad_style
         $error("reg_alu: unknown ADDER_STYLE");
      end
   endgenerate

   alu_op_e          op;
   logic [WIDTH-1:0] arith_sum;
   logic             arith_cout;
   logic [WIDTH-1:0] logic_res;
   logic             carry_n;
   logic             ovf_n;
   logic [WIDTH-1:0] result_n;
   logic             zero_n;

   assign op = alu_op_e'(opcode);

   reg_alu_addsub #(.WIDTH(WIDTH), .STYLE(ADDER_STYLE)) u_addsub (
      .a    (opa),
      .b    (opb),
      .sub  (op_is_sub(op)),
      .sum  (arith_sum),
      .cout (arith_cout)
   );

   reg_alu_logic #(.WIDTH(WIDTH)) u_logic (
      .a   (opa),
      .b   (opb),
      .op  (op),
      .res (logic_res)
   );

   reg_alu_flags u_flags (
      .op      (op),
      .a_msb   (opa[MSB]),
      .b_msb   (opb[MSB]),
      .s_msb   (arith_sum[MSB]),
      .cout    (arith_cout),
      .carry_n (carry_n),
      .ovf_n   (ovf_n)
   );

   assign result_n = op_is_arith(op) ? arith_sum : logic_res;
   assign zero_n   = ~|result_n;

   always_ff @(posedge clk) begin
      if (rst) begin
         result <= '0;
         carry  <= 1'b0;
         ovf    <= 1'b0;
         zero   <= 1'b0;
      end else begin
         result <= result_n;
         carry  <= carry_n;
         ovf    <= ovf_n;
         zero   <= zero_n;
      end
   end
endmodule

// File: rtl/reg_alu_chk.sv
module reg_alu_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst,
   input logic [WIDTH-1:0] opa,
   input logic [WIDTH-1:0] opb,
   input logic [2:0]       opcode,
   input logic [WIDTH-1:0] result,
   input logic             carry,
   input logic             ovf,
   input logic             zero
);
   // R11
   rst_clear_chk: assert property (@(posedge clk)
      rst |=> (result == '0) && !carry && !ovf && !zero);

   // R9
   zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (zero == (result == '0)));

   // R4
   addu_sum_chk: assert property (@(posedge clk) disable iff (rst)
      (opcode == 3'b000) |=>
         ({carry, result} == ({1'b0, $past(opa)} + {1'b0, $past(opb)})));

   // R5
   subu_borrow_chk: assert property (@(posedge clk) disable iff (rst)
      (opcode == 3'b010) |=> (carry == ($past(opa) < $past(opb))));

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      (opcode != 3'b001 && opcode != 3'b011) |=> !ovf);

   // R8
   no_carry_chk: assert property (@(posedge clk) disable iff (rst)
      (opcode != 3'b000 && opcode != 3'b010) |=> !carry);

   // R3
   half_msb_chk: assert property (@(posedge clk) disable iff (rst)
      (opcode == 3'b111) |=> (result[WIDTH-1] == 1'b0) &&
                             (result[WIDTH-2:0] == $past(opa[WIDTH-1:1])));
endmodule

bind reg_alu reg_alu_chk #(.WIDTH(WIDTH)) u_reg_alu_chk (
   .clk    (clk),
   .rst    (rst),
   .opa    (opa),
   .opb    (opb),
   .opcode (opcode),
   .result (result),
   .carry  (carry),
   .ovf    (ovf),
   .zero   (zero)
);

// File: tb/reg_alu_test.sv
`timescale 1ns/1ps
module reg_alu_test;
   localparam int W = 8;

   typedef struct {
      logic [W-1:0] res;
      logic         c;
      logic         v;
      logic         z;
      string        tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] opa = '0;
   logic [W-1:0] opb = '0;
   logic [2:0]   opcode = 3'b000;
   logic [W-1:0] result;
   logic         carry, ovf, zero;

   int total = 0;
   int bad   = 0;
   bit done  = 0;
   exp_t sb[$];

   always #2 clk = ~clk;

   reg_alu #(.WIDTH(W), .ADDER_STYLE(1)) uut (
      .clk(clk), .rst(rst), .opa(opa), .opb(opb), .opcode(opcode),
      .result(result), .carry(carry), .ovf(ovf), .zero(zero)
   );

   function automatic exp_t model(input logic [W-1:0] a, input logic [W-1:0] b,
                                  input logic [2:0] op, input string tag);
      exp_t e;
      logic [W:0] wide;
      e.c = 1'b0; e.v = 1'b0; e.tag = tag;
      case (op)
         3'b000: begin wide = {1'b0, a} + {1'b0, b}; e.res = wide[W-1:0]; e.c = wide[W]; end
         3'b001: begin e.res = a + b;
                       e.v = (a[W-1] == b[W-1]) && (e.res[W-1] != a[W-1]); end
         3'b010: begin e.res = a - b; e.c = (a < b); end
         3'b011: begin e.res = a - b;
                       e.v = (a[W-1] != b[W-1]) && (e.res[W-1] != a[W-1]); end
         3'b100: e.res = a & b;
         3'b101: e.res = a | b;
         3'b110: e.res = a ^ b;
         default: e.res = a / 2;
      endcase
      e.z = (e.res == '0);
      return e;
   endfunction

   task automatic check(input string tag, input logic [W+2:0] act, input logic [W+2:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [2:0] op, input string tag);
      @(negedge clk);
      opa = a; opb = b; opcode = op;
      @(posedge clk);
      #1 sb.push_back(model(a, b, op, tag));
   endtask

   // monitor: pops one expected item per result cycle
   initial begin
      forever begin
         @(negedge clk);
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, {result, carry, ovf, zero}, {e.res, e.c, e.v, e.z});
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R11: reset state
      opa = 8'h00; opb = 8'h00; opcode = 3'b000;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R11 reset", {result, carry, ovf, zero}, {8'h00, 3'b000});
      rst = 1'b0;

      drive(8'hFF, 8'h01, 3'b000, "R4 addu wrap carry");
      drive(8'h12, 8'h34, 3'b000, "R1 addu plain");
      drive(8'h7F, 8'h01, 3'b001, "R6 adds pos ovf");
      drive(8'h80, 8'hFF, 3'b001, "R6 adds neg ovf");
      drive(8'hFF, 8'h01, 3'b001, "R6 adds no ovf zero");
      drive(8'h05, 8'h07, 3'b010, "R5 subu borrow");
      drive(8'h07, 8'h05, 3'b010, "R5 subu no borrow");
      drive(8'h00, 8'h00, 3'b010, "R9 subu zero");
      drive(8'h80, 8'h01, 3'b011, "R7 subs neg ovf");
      drive(8'h7F, 8'hFF, 3'b011, "R7 subs pos ovf");
      drive(8'h05, 8'h03, 3'b011, "R7 subs no ovf");
      drive(8'hF0, 8'h3C, 3'b100, "R2 and");
      drive(8'hF0, 8'h3C, 3'b101, "R2 or");
      drive(8'hAA, 8'hAA, 3'b110, "R2 xor zero");
      drive(8'hFF, 8'hAA, 3'b111, "R3 half");
      drive(8'hFF, 8'h55, 3'b111, "R3 half opb ignored");
      drive(8'h01, 8'hFF, 3'b111, "R3 half to zero");
      drive(8'hFF, 8'hFF, 3'b100, "R8 and no flags");

      // R10: a new input does not change outputs before the next edge
      @(negedge clk);
      opa = 8'h01; opb = 8'h01; opcode = 3'b000;
      #1 check("R10 hold", {result, carry, ovf, zero}, {8'hFF, 3'b000});
      @(posedge clk);
      #1 sb.push_back(model(8'h01, 8'h01, 3'b000, "R10 update"));

      // R12/R1/R8: sweep of pseudo-random operands on every opcode
      for (int i = 0; i < 64; i++) begin
         logic [W-1:0] a, b;
         a = W'((i * 37 + 11) ^ (i << 3));
         b = W'((i * 91 + 5) ^ (i >> 1));
         drive(a, b, 3'(i), "R12 sweep");
      end

      // R11: reset in mid-run clears outputs
      @(negedge clk);
      opa = 8'hFF; opb = 8'h01; opcode = 3'b000;
      rst = 1'b1;
      @(negedge clk);
      check("R11 mid reset", {result, carry, ovf, zero}, {8'h00, 3'b000});
      rst = 1'b0;

      drive(8'h00, 8'h01, 3'b010, "R5 borrow after reset");
      repeat (3) @(negedge clk);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule